// File: doc/BRIEF.md
# TFT Frame-Buffer Scan-Out Controller

This block reads a true-colour image out of system memory and drives it to a TFT or VGA panel. It makes its own horizontal and vertical timing. By default the timing is the 640x480 mode: 800 clocks per line and 525 lines per frame, with active-low sync pulses. For every visible pixel it issues one word read on a synchronous memory port. The port has one cycle of latency. The block presents the returned colour on 8-bit red, green and blue outputs together with a data-enable strobe.

Software controls the block through two registers on a simple valid/write port. The base register holds the byte address of the image. Only its 11 most significant bits are kept, so an image always starts on a 2 MiB boundary. The control register has a display-on bit and a 180-degree flip bit. Each image row takes 1024 words of memory, and only the first 640 words of a row are fetched. A new base address or flip setting is applied from the next frame onward, so a frame already on screen is never torn. The display-on bit acts at once.

Top module: `tft_scanout`

## Requirements
- R1: `reg_addr` is a byte offset. Offset 0 selects the base register and offset 4 selects the control register. A write or read at any other offset, including a misaligned one, changes nothing and reads as zero. A read returns the stored register value in the same cycle.
- R2: The base register keeps only write data bits [31:21]. Bits [20:0] always read back as zero.
- R3: In the control register, bit 0 is display-on and bit 1 is flip. All other bits read back as zero. While reset is held, both registers read zero, `mem_rd_en` and `pix_de` are low, the colour outputs are zero and both syncs are high.
- R4: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks, with the visible pixels first. `pix_hsync_n` is low for H_SYNC clocks, starting H_ACTIVE+H_FP clocks after the first pixel of the line. Frames follow the same pattern in lines: V_ACTIVE+V_FP+V_SYNC+V_BP lines, with `pix_vsync_n` low during the V_SYNC lines. Both syncs keep running while the display is off.
- R5: With flip clear, the read for row r and column c uses word address base/4 + r*2^STRIDE_LOG2 + c, for r < V_ACTIVE and c < H_ACTIVE. Exactly one read is issued per visible pixel, and no word at column H_ACTIVE or above is ever read.
- R6: With flip set, the read for screen position (r, c) uses word address base/4 + (V_ACTIVE-1-r)*2^STRIDE_LOG2 + (H_ACTIVE-1-c).
- R7: `pix_de` goes high in the cycle after a read is issued. While it is high, red, green and blue come from bits [23:16], [15:8] and [7:0] of the returned word. Bits [31:24] are ignored.
- R8: While the display is off, no reads are issued, `pix_de` stays low and all colour outputs are zero.
- R9: A base or flip value written during a frame has no effect on that frame. It applies from the first pixel of the next frame.
- R10: A write to the display-on bit changes `mem_rd_en` in the cycle right after the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_rd_en | output | 1 | Frame-buffer read request |
| mem_addr | output | 30 | Frame-buffer word address |
| mem_rdata | input | 32 | Word returned one cycle after the request |
| pix_de | output | 1 | Pixel data enable |
| pix_red | output | 8 | Red level |
| pix_green | output | 8 | Green level |
| pix_blue | output | 8 | Blue level |
| pix_hsync_n | output | 1 | Horizontal sync, active low |
| pix_vsync_n | output | 1 | Vertical sync, active low |

## Verification
The bench carries its own model of the beam position and of the pending and live register values. It compares every output against that model on every clock, so a counter that slips or wraps late shows up as a wrong sync level or a wrong address within one line. A shadow register that loads at the wrong moment shows a different base or a mirrored address at the first pixel of the affected frame, and directed checks sample exactly there. A stale enable or a misaligned pipeline shows one cycle after the write, or as colour data one pixel off from the word that was fetched.

// File: rtl/tft_pkg.sv
package tft_pkg;
    // Register word indices (byte offset >> 2)
    localparam int unsigned IDX_BASE = 0;
    localparam int unsigned IDX_CTRL = 1;
    // Control bit positions
    localparam int unsigned CTL_ON   = 0;
    localparam int unsigned CTL_FLIP = 1;

    typedef struct packed {
        logic de;
        logic hs_n;
        logic vs_n;
    } out_pipe_t;
endpackage

// File: rtl/tft_timing.sv
module tft_timing #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int HCW      = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP),
    parameter int VCW      = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP)
) (
    input  logic           clk,
    input  logic           rst,
    output logic [HCW-1:0] h_o,
    output logic [VCW-1:0] v_o,
    output logic           active_o,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           frame_last_o
);
    localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HS_START = H_ACTIVE + H_FP;
    localparam int HS_END   = HS_START + H_SYNC;
    localparam int VS_START = V_ACTIVE + V_FP;
    localparam int VS_END   = VS_START + V_SYNC;

    typedef struct packed {
        logic [HCW-1:0] h;
        logic [VCW-1:0] v;
    } beam_t;

    beam_t beam_d, beam_q;
    logic  line_end;

    always_comb begin
        beam_d   = beam_q;
        line_end = (beam_q.h == HCW'(H_TOTAL - 1));
        if (line_end) begin
            beam_d.h = '0;
            if (beam_q.v == VCW'(V_TOTAL - 1)) begin
                beam_d.v = '0;
            end else begin
                beam_d.v = beam_q.v + 1'b1;
            end
        end else begin
            beam_d.h = beam_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beam_q <= '0;
        end else begin
            beam_q <= beam_d;
        end
    end

    assign h_o          = beam_q.h;
    assign v_o          = beam_q.v;
    assign active_o     = (beam_q.h < HCW'(H_ACTIVE)) && (beam_q.v < VCW'(V_ACTIVE));
    assign hsync_o      = (beam_q.h >= HCW'(HS_START)) && (beam_q.h < HCW'(HS_END));
    assign vsync_o      = (beam_q.v >= VCW'(VS_START)) && (beam_q.v < VCW'(VS_END));
    assign frame_last_o = line_end && (beam_q.v == VCW'(V_TOTAL - 1));

    // R4: beam position never leaves the line / frame
    a_r4_beam_bounds: assert property (@(posedge clk) disable iff (rst)
        (int'(beam_q.h) < H_TOTAL) && (int'(beam_q.v) < V_TOTAL))
        else $error("beam position out of range");
endmodule

// File: rtl/tft_regs.sv
module tft_regs #(
    parameter int ADDR_W    = 32,
    parameter int BASE_KEEP = 11,
    parameter int REG_AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    input  logic                 frame_last_i,
    output logic                 on_o,
    output logic                 flip_live_o,
    output logic [BASE_KEEP-1:0] base_live_o
);
    import tft_pkg::*;

    typedef struct packed {
        logic [BASE_KEEP-1:0] base;
        logic                 on;
        logic                 flip;
        logic [BASE_KEEP-1:0] live_base;
        logic                 live_flip;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  aligned, hit_base, hit_ctrl;
    logic  wdata_unused;

    assign aligned  = (reg_addr[1:0] == 2'b00);
    assign hit_base = aligned && (reg_addr[REG_AW-1:2] == (REG_AW-2)'(IDX_BASE));
    assign hit_ctrl = aligned && (reg_addr[REG_AW-1:2] == (REG_AW-2)'(IDX_CTRL));
    assign wdata_unused = ^reg_wdata[ADDR_W-BASE_KEEP-1:2];

    always_comb begin
        regs_d = regs_q;
        if (reg_valid && reg_write && hit_base) begin
            regs_d.base = reg_wdata[ADDR_W-1 -: BASE_KEEP];
        end
        if (reg_valid && reg_write && hit_ctrl) begin
            regs_d.on   = reg_wdata[CTL_ON];
            regs_d.flip = reg_wdata[CTL_FLIP];
        end
        if (frame_last_i) begin
            regs_d.live_base = regs_q.base;
            regs_d.live_flip = regs_q.flip;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_base) begin
            reg_rdata = {regs_q.base, {(ADDR_W-BASE_KEEP){1'b0}}};
        end else if (hit_ctrl) begin
            reg_rdata[CTL_ON]   = regs_q.on;
            reg_rdata[CTL_FLIP] = regs_q.flip;
        end
    end

    assign on_o        = regs_q.on;
    assign flip_live_o = regs_q.live_flip;
    assign base_live_o = regs_q.live_base;

    // R9: the live base and flip only move at the frame boundary
    a_r9_live_held: assert property (@(posedge clk) disable iff (rst)
        !frame_last_i |=> ($stable(regs_q.live_base) && $stable(regs_q.live_flip)))
        else $error("live base/flip changed mid-frame");
endmodule

// File: rtl/tft_fetch.sv
module tft_fetch #(
    parameter int H_ACTIVE    = 640,
    parameter int V_ACTIVE    = 480,
    parameter int STRIDE_LOG2 = 10,
    parameter int MAW         = 30,
    parameter int BASE_KEEP   = 11,
    parameter int HCW         = 10,
    parameter int VCW         = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HCW-1:0]       h_i,
    input  logic [VCW-1:0]       v_i,
    input  logic                 active_i,
    input  logic                 hsync_i,
    input  logic                 vsync_i,
    input  logic                 on_i,
    input  logic                 flip_i,
    input  logic [BASE_KEEP-1:0] base_live_i,
    input  logic [23:0]          word_i,
    output logic                 mem_rd_en_o,
    output logic [MAW-1:0]       mem_addr_o,
    output logic                 pix_de_o,
    output logic [7:0]           pix_red_o,
    output logic [7:0]           pix_green_o,
    output logic [7:0]           pix_blue_o,
    output logic                 pix_hsync_n_o,
    output logic                 pix_vsync_n_o
);
    import tft_pkg::*;

    out_pipe_t      pipe_d, pipe_q;
    logic [VCW-1:0] row;
    logic [HCW-1:0] col;
    logic           rd_en;
    logic [MAW-1:0] addr;

    always_comb begin
        row   = flip_i ? (VCW'(V_ACTIVE - 1) - v_i) : v_i;
        col   = flip_i ? (HCW'(H_ACTIVE - 1) - h_i) : h_i;
        rd_en = active_i && on_i;
        addr  = {base_live_i, {(MAW-BASE_KEEP){1'b0}}}
              + (MAW'(row) << STRIDE_LOG2)
              + MAW'(col);
        pipe_d.de   = rd_en;
        pipe_d.hs_n = ~hsync_i;
        pipe_d.vs_n = ~vsync_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign mem_rd_en_o   = rd_en;
    assign mem_addr_o    = addr;
    assign pix_de_o      = pipe_q.de;
    assign pix_red_o     = pipe_q.de ? word_i[23:16] : 8'h00;
    assign pix_green_o   = pipe_q.de ? word_i[15:8]  : 8'h00;
    assign pix_blue_o    = pipe_q.de ? word_i[7:0]   : 8'h00;
    assign pix_hsync_n_o = pipe_q.hs_n;
    assign pix_vsync_n_o = pipe_q.vs_n;

    // R5: a read never touches the unused tail of a row
    a_r5_col_in_range: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en_o |-> (int'(mem_addr_o[STRIDE_LOG2-1:0]) < H_ACTIVE))
        else $error("read beyond visible columns");

    // R4: no pixel is shown during vertical sync
    a_r4_vsync_blank: assert property (@(posedge clk) disable iff (rst)
        !pix_vsync_n_o |-> !pix_de_o)
        else $error("data enable during vsync");
endmodule

// File: rtl/tft_scanout.sv
module tft_scanout #(
    parameter int H_ACTIVE    = 640,
    parameter int H_FP        = 16,
    parameter int H_SYNC      = 96,
    parameter int H_BP        = 48,
    parameter int V_ACTIVE    = 480,
    parameter int V_FP        = 10,
    parameter int V_SYNC      = 2,
    parameter int V_BP        = 33,
    parameter int STRIDE_LOG2 = 10,
    parameter int ADDR_W      = 32,
    parameter int BASE_KEEP   = 11,
    parameter int REG_AW      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_rd_en,
    output logic [ADDR_W-3:0] mem_addr,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              pix_de,
    output logic [7:0]        pix_red,
    output logic [7:0]        pix_green,
    output logic [7:0]        pix_blue,
    output logic              pix_hsync_n,
    output logic              pix_vsync_n
);
    localparam int MAW = ADDR_W - 2;
    localparam int HCW = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP);
    localparam int VCW = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP);

    logic [HCW-1:0]       h_w;
    logic [VCW-1:0]       v_w;
    logic                 active_w, hsync_w, vsync_w, frame_last_w;
    logic                 on_w, flip_w;
    logic [BASE_KEEP-1:0] base_w;
    logic                 rdata_unused;

    assign rdata_unused = ^mem_rdata[ADDR_W-1:24];

    tft_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HCW(HCW), .VCW(VCW)
    ) u_timing (
        .clk(clk), .rst(rst),
        .h_o(h_w), .v_o(v_w), .active_o(active_w),
        .hsync_o(hsync_w), .vsync_o(vsync_w), .frame_last_o(frame_last_w)
    );

    tft_regs #(
        .ADDR_W(ADDR_W), .BASE_KEEP(BASE_KEEP), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst(rst),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_last_i(frame_last_w),
        .on_o(on_w), .flip_live_o(flip_w), .base_live_o(base_w)
    );

    tft_fetch #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .STRIDE_LOG2(STRIDE_LOG2),
        .MAW(MAW), .BASE_KEEP(BASE_KEEP), .HCW(HCW), .VCW(VCW)
    ) u_fetch (
        .clk(clk), .rst(rst),
        .h_i(h_w), .v_i(v_w), .active_i(active_w),
        .hsync_i(hsync_w), .vsync_i(vsync_w),
        .on_i(on_w), .flip_i(flip_w), .base_live_i(base_w),
        .word_i(mem_rdata[23:0]),
        .mem_rd_en_o(mem_rd_en), .mem_addr_o(mem_addr),
        .pix_de_o(pix_de), .pix_red_o(pix_red), .pix_green_o(pix_green),
        .pix_blue_o(pix_blue), .pix_hsync_n_o(pix_hsync_n), .pix_vsync_n_o(pix_vsync_n)
    );

    // R7: every shown pixel was requested one cycle earlier
    a_r7_de_after_read: assert property (@(posedge clk) disable iff (rst)
        pix_de |-> $past(mem_rd_en))
        else $error("pixel shown without a read");

    // R8: display off means no traffic towards memory
    a_r8_no_read_when_off: assert property (@(posedge clk) disable iff (rst)
        !on_w |-> !mem_rd_en)
        else $error("read issued while display off");
endmodule

// File: tb/sim_tft_scanout.sv
module sim_tft_scanout;
    localparam int HA = 8, HF = 2, HS = 3, HB = 2;
    localparam int VA = 4, VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en;
    logic [29:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        pix_de, pix_hsync_n, pix_vsync_n;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int n_chk = 0, n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tft_scanout #(
        .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
    ) u0 (
        .clk(clk), .rst(rst),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pix_de(pix_de), .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
        .pix_hsync_n(pix_hsync_n), .pix_vsync_n(pix_vsync_n)
    );

    function automatic logic [31:0] mem_word(input logic [29:0] a);
        return ({2'b00, a} * 32'h9E37_79B1) ^ 32'hC300_0000;
    endfunction

    function automatic bit vis(input int h, input int v);
        return (h < HA) && (v < VA);
    endfunction

    function automatic logic [29:0] want_addr(input logic [31:0] base, input bit rot,
                                              input int h, input int v);
        int r, c;
        r = rot ? (VA - 1 - v) : v;
        c = rot ? (HA - 1 - h) : h;
        return base[31:2] + 30'(r * 1024) + 30'(c);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory with one cycle of latency
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(mem_addr);

    // reference model from the requirements
    int          mh = 0, mv = 0;
    logic [31:0] m_base = '0, m_live_base = '0;
    logic [1:0]  m_ctl = '0;
    logic        m_live_rot = 1'b0;
    logic        e_de = 1'b0, e_hs = 1'b1, e_vs = 1'b1;
    logic [31:0] e_word = '0;

    always @(posedge clk) begin
        if (rst) begin
            mh <= 0; mv <= 0; m_base <= '0; m_ctl <= '0;
            m_live_base <= '0; m_live_rot <= 1'b0;
            e_de <= 1'b0; e_hs <= 1'b1; e_vs <= 1'b1;
        end else begin
            if (reg_valid && reg_write && reg_addr == 4'd0) m_base <= reg_wdata & 32'hFFE0_0000;
            if (reg_valid && reg_write && reg_addr == 4'd4) m_ctl  <= reg_wdata[1:0];
            if (mh == HT - 1 && mv == VT - 1) begin
                m_live_base <= m_base;
                m_live_rot  <= m_ctl[1];
            end
            e_de <= vis(mh, mv) && m_ctl[0];
            e_hs <= !(mh >= HA + HF && mh < HA + HF + HS);
            e_vs <= !(mv >= VA + VF && mv < VA + VF + VS);
            if (vis(mh, mv) && m_ctl[0]) e_word <= mem_word(want_addr(m_live_base, m_live_rot, mh, mv));
            if (mh == HT - 1) begin
                mh <= 0;
                mv <= (mv == VT - 1) ? 0 : mv + 1;
            end else begin
                mh <= mh + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            bit          exp_rd;
            logic [23:0] exp_rgb;
            exp_rd  = vis(mh, mv) && m_ctl[0];
            exp_rgb = e_de ? e_word[23:0] : 24'h0;
            chk(mem_rd_en === exp_rd, "R10/R8 read enable", 32'(mem_rd_en), 32'(exp_rd));
            if (exp_rd) begin
                if (m_live_rot)
                    chk(mem_addr === want_addr(m_live_base, 1'b1, mh, mv), "R6 flipped address",
                        32'(mem_addr), 32'(want_addr(m_live_base, 1'b1, mh, mv)));
                else
                    chk(mem_addr === want_addr(m_live_base, 1'b0, mh, mv), "R5 address",
                        32'(mem_addr), 32'(want_addr(m_live_base, 1'b0, mh, mv)));
            end
            chk(pix_de === e_de, "R7 data enable", 32'(pix_de), 32'(e_de));
            chk({pix_red, pix_green, pix_blue} === exp_rgb, "R7 colour",
                32'({pix_red, pix_green, pix_blue}), 32'(exp_rgb));
            chk(pix_hsync_n === e_hs, "R4 hsync", 32'(pix_hsync_n), 32'(e_hs));
            chk(pix_vsync_n === e_vs, "R4 vsync", 32'(pix_vsync_n), 32'(e_vs));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic wait_pos(input int h, input int v);
        @(negedge clk);
        while (!(mh == h && mv == v)) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_ret;
        seed_ret = $urandom(32'd4242);

        // R3: reset state
        repeat (3) @(negedge clk);
        chk(!mem_rd_en && !pix_de, "R3 reset read/de", 32'({mem_rd_en, pix_de}), 32'h0);
        chk({pix_red, pix_green, pix_blue} == 24'h0, "R3 reset colour",
            32'({pix_red, pix_green, pix_blue}), 32'h0);
        chk(pix_hsync_n && pix_vsync_n, "R3 reset syncs", 32'({pix_hsync_n, pix_vsync_n}), 32'h3);
        rst = 1'b0;
        cmp_on = 1'b1;
        rd(4'd0, v); chk(v == 32'h0, "R3 base reset", v, 32'h0);
        rd(4'd4, v); chk(v == 32'h0, "R3 ctrl reset", v, 32'h0);

        // R2: base keeps bits [31:21]
        wr(4'd0, 32'h1234_5678);
        rd(4'd0, v); chk(v == 32'h1220_0000, "R2 base mask", v, 32'h1220_0000);
        // R3: only control bits 0 and 1 stored
        wr(4'd4, 32'hFFFF_FFFD);
        rd(4'd4, v); chk(v == 32'h1, "R3 ctrl bits", v, 32'h1);
        // R1: unmapped and misaligned offsets
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd12, 32'hFFFF_FFFF);
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd5, 32'h0);
        rd(4'd8, v);  chk(v == 32'h0, "R1 unmapped read", v, 32'h0);
        rd(4'd1, v);  chk(v == 32'h0, "R1 misaligned read", v, 32'h0);
        rd(4'd0, v);  chk(v == 32'h1220_0000, "R1 base untouched", v, 32'h1220_0000);
        rd(4'd4, v);  chk(v == 32'h1, "R1 ctrl untouched", v, 32'h1);

        // R5/R7/R4: run full frames unflipped
        repeat (3 * HT * VT) @(negedge clk);

        // R9: base written mid-frame waits for next frame
        wait_pos(2, 1);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'd0; reg_wdata = 32'hA440_0000;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        chk(mem_addr[29:19] == 11'h091, "R9 old base kept", 32'(mem_addr[29:19]), 32'h091);
        wait_pos(0, 0);
        chk(mem_addr == {11'h522, 19'h0}, "R9 new base at frame start", 32'(mem_addr),
            32'({11'h522, 19'h0}));

        // R6/R9: flip written mid-frame, first flipped pixel next frame
        wait_pos(4, 2);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h3;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        chk(mem_addr == {11'h522, 19'h0} + 30'(2 * 1024 + 5), "R9 flip deferred",
            32'(mem_addr), 32'({11'h522, 19'h0} + 30'(2 * 1024 + 5)));
        wait_pos(0, 0);
        chk(mem_addr == {11'h522, 19'h0} + 30'((VA - 1) * 1024 + HA - 1), "R6 first flipped pixel",
            32'(mem_addr), 32'({11'h522, 19'h0} + 30'((VA - 1) * 1024 + HA - 1)));
        repeat (2 * HT * VT) @(negedge clk);

        // R10/R8: switch off mid-line, then back on
        wait_pos(1, 1);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h0;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        chk(!mem_rd_en, "R10 read stops next cycle", 32'(mem_rd_en), 32'h0);
        @(negedge clk);
        chk(!pix_de && {pix_red, pix_green, pix_blue} == 24'h0, "R8 dark output",
            32'({pix_de, pix_red, pix_green, pix_blue}), 32'h0);
        repeat (HT * VT) @(negedge clk);
        wait_pos(3, 2);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h1;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        chk(mem_rd_en, "R10 read restarts next cycle", 32'(mem_rd_en), 32'h1);

        // random register traffic, checked by the model every clock
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) begin
                logic [31:0] d;
                logic [3:0]  a;
                a = 4'($urandom_range(0, 3) << 2);
                if ($urandom_range(0, 7) == 0) a = 4'($urandom_range(0, 15));
                d = $urandom;
                if ($urandom_range(0, 3) != 0) d[0] = 1'b1;
                wr(a, d);
            end else begin
                @(negedge clk);
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule